// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Packed Status Register

This block is the arithmetic and flag stage of a small 8-bit accumulator processor. On each clock edge where an operation is presented, it combines the accumulator value and a memory operand under a 4-bit operation code. It registers the 8-bit result and updates its internal flag register: negative, overflow, zero and carry, plus the interrupt-mask, decimal and break bits that it only stores.

The flag register can be loaded from a packed status byte, and it is always visible in packed form. This lets a sequencer push and pull the processor status without knowing the bit layout. Decimal arithmetic is not implemented. An add or subtract requested while the decimal bit is set raises a one-cycle error and changes nothing.

Single-operand operations (shifts, rotates, increment, decrement) act on the memory operand. The sequencer routes the accumulator there for the accumulator forms.

Top module: `alu_status_unit`

## Requirements
- R1: A synchronous active-high reset drives `result` to 0x00, every stored flag to 0 (so `status_out` reads 0x20) and `dec_err` to 0.
- R2: Code 0 (add) produces A + M + C truncated to 8 bits. C is set when the unsigned sum exceeds 0xFF. V is set when the signed sum lies outside -128..127.
- R3: Code 1 (subtract) produces A - M - (1 - C). C is set when the unsigned difference is not negative (no borrow). V flags signed overflow.
- R4: Codes 2, 3 and 4 (AND, OR, XOR of A and M) update only N and Z.
- R5: Codes 5 and 6 shift M left or right by one, shifting in 0. C takes the bit shifted out. V is kept.
- R6: Code 7 rotates M left, with old C entering bit 0 and bit 7 going to C. Code 8 rotates M right, with old C entering bit 7 and bit 0 going to C.
- R7: Code 9 (compare) sets C when A >= M unsigned and sets N and Z from the 8-bit A - M. It keeps V and returns A unchanged as the result.
- R8: Code 10 (bit test) copies M bit 7 to N and M bit 6 to V, and sets Z when A AND M is zero. It keeps C and returns A as the result.
- R9: Codes 11 and 12 add or subtract one from M modulo 256 and update only N and Z.
- R10: For every result-producing operation, Z is set exactly when the 8-bit result (the difference, for compare) is zero, and N equals its bit 7.
- R11: `status_out` packs C at bit 0, Z at bit 1, I at bit 2, D at bit 3, B at bit 4, constant 1 at bit 5, V at bit 6 and N at bit 7. A cycle with `flag_load` high loads all seven flags from `flag_din` at those positions, ignores `flag_din` bit 5, and takes priority over any operation in the same cycle.
- R12: Add or subtract with D set raises `dec_err` for exactly the next cycle and leaves `result` and the flags unchanged. `dec_err` is 0 after every other cycle.
- R13: When `op_valid` is low, or the code is 13 to 15, `result` and the flags keep their values. Otherwise both are updated at the clock edge where the operation is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector, codes 0 to 12 |
| a_in | input | 8 | Accumulator value |
| m_in | input | 8 | Memory operand |
| flag_load | input | 1 | Load the flags from `flag_din` |
| flag_din | input | 8 | Packed status byte to unpack |
| result | output | 8 | Registered operation result |
| status_out | output | 8 | Packed flag register |
| dec_err | output | 1 | Add/subtract refused because decimal bit is set |

## Verification
The bench targets signed overflow at both edges (0x50+0x50, 0x50-0xB0), carry out at 0xFF+1, and subtract with and without incoming borrow. A design that derived V from the unsigned carry, or inverted the no-borrow sense, would report the wrong C or V on these operands. Rotates are run with both carry values, compare is run on equal operands, and the bit test is run with an operand whose top bits disagree with the result. These catch a rotate that drops the old carry, a compare that writes A or V, and a bit test that takes N from A AND M. A status load is checked with bit 5 cleared, and add and subtract are tried with D set, to expose a packed byte that reads the raw bit 5 and a decimal request that corrupts state. Random operations with random flag loads are then compared against a bench model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW  = 8;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_ROTL = 4'd7,
    OP_ROTR = 4'd8,
    OP_CMP  = 4'd9,
    OP_BIT  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12
  } alu_op_e;

  // bit positions inside the packed status byte
  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_1 = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic brk;
    logic dec;
    logic irq_mask;
    logic zero;
    logic carry;
  } flags_t;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];
  // signed overflow: operands agree in sign, sum disagrees
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] m_val,
  input  flags_t       f_in,
  output logic [W-1:0] res,
  output flags_t       f_out,
  output logic         op_known
);
  logic [W-1:0] add_y;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic [W:0]   cmp_wide;
  logic [W-1:0] nz_src;
  logic         nz_en;

  // subtract reuses the adder as A + ~M + C
  assign add_y = (op == OP_SUB) ? ~m_val : m_val;

  alu_adder #(.W(W)) u_add (
    .x   (a_val),
    .y   (add_y),
    .cin (f_in.carry),
    .sum (add_sum),
    .cout(add_cout),
    .ovf (add_ovf)
  );

  // compare: A + ~M + 1, carry out means A >= M
  assign cmp_wide = {1'b0, a_val} + {1'b0, ~m_val} + {{W{1'b0}}, 1'b1};

  always_comb begin
    res      = a_val;
    f_out    = f_in;
    op_known = 1'b1;
    nz_en    = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        res         = add_sum;
        f_out.carry = add_cout;
        f_out.ovf   = add_ovf;
      end
      OP_AND: res = a_val & m_val;
      OP_OR:  res = a_val | m_val;
      OP_XOR: res = a_val ^ m_val;
      OP_SHL: begin
        res         = {m_val[W-2:0], 1'b0};
        f_out.carry = m_val[W-1];
      end
      OP_SHR: begin
        res         = {1'b0, m_val[W-1:1]};
        f_out.carry = m_val[0];
      end
      OP_ROTL: begin
        res         = {m_val[W-2:0], f_in.carry};
        f_out.carry = m_val[W-1];
      end
      OP_ROTR: begin
        res         = {f_in.carry, m_val[W-1:1]};
        f_out.carry = m_val[0];
      end
      OP_CMP: begin
        res         = a_val;
        f_out.carry = cmp_wide[W];
      end
      OP_BIT: begin
        res        = a_val;
        nz_en      = 1'b0;
        f_out.neg  = m_val[W-1];
        f_out.ovf  = m_val[W-2];
        f_out.zero = ((a_val & m_val) == '0);
      end
      OP_INC: res = m_val + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res = m_val - {{(W-1){1'b0}}, 1'b1};
      default: begin
        op_known = 1'b0;
        nz_en    = 1'b0;
      end
    endcase
    nz_src = (op == OP_CMP) ? cmp_wide[W-1:0] : res;
    if (nz_en) begin
      f_out.zero = (nz_src == '0);
      f_out.neg  = nz_src[W-1];
    end
  end
endmodule

// File: rtl/alu_status_pack.sv
module alu_status_pack
  import alu_pkg::*;
(
  input  flags_t     f_cur,
  output logic [7:0] packed_out,
  input  logic [7:0] packed_in,
  output flags_t     f_unpacked
);
  logic unused_fixed_bit;

  always_comb begin
    packed_out       = 8'h00;
    packed_out[SB_C] = f_cur.carry;
    packed_out[SB_Z] = f_cur.zero;
    packed_out[SB_I] = f_cur.irq_mask;
    packed_out[SB_D] = f_cur.dec;
    packed_out[SB_B] = f_cur.brk;
    packed_out[SB_1] = 1'b1;
    packed_out[SB_V] = f_cur.ovf;
    packed_out[SB_N] = f_cur.neg;
  end

  assign f_unpacked.carry    = packed_in[SB_C];
  assign f_unpacked.zero     = packed_in[SB_Z];
  assign f_unpacked.irq_mask = packed_in[SB_I];
  assign f_unpacked.dec      = packed_in[SB_D];
  assign f_unpacked.brk      = packed_in[SB_B];
  assign f_unpacked.ovf      = packed_in[SB_V];
  assign f_unpacked.neg      = packed_in[SB_N];
  assign unused_fixed_bit    = packed_in[SB_1];
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  a_in,
  input  logic [DW-1:0]  m_in,
  input  logic           flag_load,
  input  logic [7:0]     flag_din,
  output logic [DW-1:0]  result,
  output logic [7:0]     status_out,
  output logic           dec_err
);
  alu_op_e      op;
  logic [DW-1:0] dp_res;
  flags_t        dp_flags;
  logic          dp_known;
  flags_t        flags_q;
  flags_t        load_flags;
  logic [DW-1:0] result_q;
  logic          dec_err_q;
  logic          is_arith;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_datapath #(.W(DW)) u_dp (
    .op      (op),
    .a_val   (a_in),
    .m_val   (m_in),
    .f_in    (flags_q),
    .res     (dp_res),
    .f_out   (dp_flags),
    .op_known(dp_known)
  );

  alu_status_pack u_pack (
    .f_cur     (flags_q),
    .packed_out(status_out),
    .packed_in (flag_din),
    .f_unpacked(load_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      flags_q   <= '0;
      dec_err_q <= 1'b0;
    end else begin
      dec_err_q <= 1'b0;
      if (flag_load) begin
        flags_q <= load_flags;
      end else if (op_valid && dp_known) begin
        if (is_arith && flags_q.dec) begin
          dec_err_q <= 1'b1;
        end else begin
          result_q <= dp_res;
          flags_q  <= dp_flags;
        end
      end
    end
  end

  assign result  = result_q;
  assign dec_err = dec_err_q;

  // R12: a refused decimal add/subtract leaves result and flags untouched
  a_r12_dec_refused: assert property (@(posedge clk) disable iff (rst)
    dec_err |-> ($stable(result) && $stable(status_out)));

  // R12: add/subtract with D set is reported on the next cycle
  a_r12_dec_flagged: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op_valid && !flag_load && (op_code <= 4'd1) && status_out[SB_D])
    |-> dec_err);

  // R11: loaded byte reappears with bit 5 forced to one
  a_r11_load_roundtrip: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && flag_load) |-> (status_out == ($past(flag_din) | 8'h20)));

  // R7: compare returns A and keeps V
  a_r7_cmp_keeps_a: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op_valid && !flag_load && (op_code == 4'd9) && !status_out[SB_D])
    |-> ((result == $past(a_in)) && (status_out[SB_V] == $past(status_out[SB_V]))));

  // R8: bit test copies operand bits 7 and 6, keeps C
  a_r8_bit_copy: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op_valid && !flag_load && (op_code == 4'd10))
    |-> ((status_out[SB_N] == $past(m_in[7])) && (status_out[SB_V] == $past(m_in[6]))
         && (status_out[SB_C] == $past(status_out[SB_C]))));

  // R13: idle cycles and undefined codes change nothing
  a_r13_idle_hold: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !flag_load && (!op_valid || (op_code >= 4'd13)))
    |-> ($stable(result) && $stable(status_out) && !dec_err));
endmodule

// File: tb/test_alu_status_unit.sv
`timescale 1ns/1ps
module test_alu_status_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] a_in = 8'h00;
  logic [7:0] m_in = 8'h00;
  logic       flag_load = 1'b0;
  logic [7:0] flag_din = 8'h00;
  logic [7:0] result;
  logic [7:0] status_out;
  logic       dec_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_res  = 8'h00;
  logic [7:0] exp_stat = 8'h20;

  always #4 clk = ~clk;

  alu_status_unit i_alu_status_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .a_in(a_in), .m_in(m_in), .flag_load(flag_load), .flag_din(flag_din),
    .result(result), .status_out(status_out), .dec_err(dec_err)
  );

  function automatic string tag(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      9: return "R7";
      10: return "R8";
      11, 12: return "R9";
      default: return "R13";
    endcase
  endfunction

  // returns {dec_err, result, status}
  function automatic logic [16:0] model(input int op, input logic [7:0] a,
                                        input logic [7:0] m, input logic [7:0] st,
                                        input logic [7:0] rprev);
    logic [7:0] r;
    logic [7:0] s;
    logic [7:0] nzv;
    int c, t, ts;
    s = st;
    r = rprev;
    c = int'(st[0]);
    if (op > 12) return {1'b0, rprev, st};
    if ((op <= 1) && st[3]) return {1'b1, rprev, st};
    case (op)
      0: begin
        t  = int'(a) + int'(m) + c;
        ts = int'($signed(a)) + int'($signed(m)) + c;
        r = t[7:0]; s[0] = (t > 255); s[6] = (ts > 127) || (ts < -128);
      end
      1: begin
        t  = int'(a) - int'(m) - (1 - c);
        ts = int'($signed(a)) - int'($signed(m)) - (1 - c);
        r = t[7:0]; s[0] = (t >= 0); s[6] = (ts > 127) || (ts < -128);
      end
      2: r = a & m;
      3: r = a | m;
      4: r = a ^ m;
      5: begin r = {m[6:0], 1'b0}; s[0] = m[7]; end
      6: begin r = {1'b0, m[7:1]}; s[0] = m[0]; end
      7: begin r = {m[6:0], st[0]}; s[0] = m[7]; end
      8: begin r = {st[0], m[7:1]}; s[0] = m[0]; end
      9: begin t = int'(a) - int'(m); r = a; s[0] = (t >= 0); end
      10: begin r = a; s[7] = m[7]; s[6] = m[6]; s[1] = ((a & m) == 8'h00); end
      11: r = m + 8'd1;
      default: r = m - 8'd1;
    endcase
    if (op != 10) begin
      nzv = (op == 9) ? (a - m) : r;
      s[1] = (nzv == 8'h00);
      s[7] = nzv[7];
    end
    s[5] = 1'b1;
    return {1'b0, r, s};
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got err=%0b res=%02h stat=%02h, expected err=%0b res=%02h stat=%02h",
               req, act[16], act[15:8], act[7:0], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic do_op(input int op, input logic [7:0] a, input logic [7:0] m, input logic valid);
    logic [16:0] e;
    @(negedge clk);
    op_valid = valid; op_code = 4'(op); a_in = a; m_in = m; flag_load = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    if (valid) e = model(op, a, m, exp_stat, exp_res);
    else e = {1'b0, exp_res, exp_stat};
    check(valid ? tag(op) : "R13", {dec_err, result, status_out}, e);
    exp_res = e[15:8]; exp_stat = e[7:0];
  endtask

  task automatic do_load(input logic [7:0] din, input logic with_op);
    @(negedge clk);
    flag_load = 1'b1; flag_din = din;
    op_valid = with_op; op_code = 4'd2; a_in = 8'hFF; m_in = 8'h00;
    @(negedge clk);
    flag_load = 1'b0; op_valid = 1'b0;
    exp_stat = din | 8'h20;
    check("R11", {dec_err, result, status_out}, {1'b0, exp_res, exp_stat});
  endtask

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {dec_err, result, status_out}, {1'b0, 8'h00, 8'h20});

    do_op(0, 8'h50, 8'h50, 1'b1);   // R2 signed overflow, N set
    do_op(0, 8'hFF, 8'h01, 1'b1);   // R2 carry out, Z set (R10)
    do_op(0, 8'h10, 8'h20, 1'b1);   // R2 with carry in
    do_load(8'h01, 1'b0);           // R11 set C
    do_op(1, 8'h50, 8'hB0, 1'b1);   // R3 signed overflow, borrow
    do_op(1, 8'h50, 8'h10, 1'b1);   // R3 borrow in
    do_op(9, 8'h42, 8'h42, 1'b1);   // R7 equal
    do_op(9, 8'h10, 8'h20, 1'b1);   // R7 less
    do_op(10, 8'h3F, 8'hC0, 1'b1);  // R8 N,V from operand, Z set
    do_op(8, 8'h00, 8'h01, 1'b1);   // R6 rotate right
    do_op(7, 8'h00, 8'h80, 1'b1);   // R6 rotate left, C in and out
    do_op(5, 8'h00, 8'h81, 1'b1);   // R5
    do_op(6, 8'h00, 8'h01, 1'b1);   // R5
    do_op(11, 8'h00, 8'hFF, 1'b1);  // R9 wrap to zero
    do_op(12, 8'h00, 8'h00, 1'b1);  // R9 wrap to FF
    do_op(4, 8'hAA, 8'hAA, 1'b1);   // R4
    do_load(8'hDF, 1'b1);           // R11 bit 5 ignored, load beats op
    do_op(0, 8'h01, 8'h01, 1'b1);   // R12 decimal refused
    do_op(1, 8'h01, 8'h01, 1'b1);   // R12 decimal refused
    do_op(0, 8'h01, 8'h01, 1'b0);   // R13 idle
    do_op(14, 8'h01, 8'h01, 1'b1);  // R13 undefined code
    do_load(8'h00, 1'b0);

    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 16) == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (($urandom % 4) != 0) d[3] = 1'b0;
        do_load(d, 1'($urandom % 2));
      end else begin
        do_op(int'($urandom % 16), 8'($urandom), 8'($urandom), 1'($urandom % 8 != 0));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule